// File: doc/BRIEF.md
# Down-counting reload timer

This block is a memory-mapped countdown timer for use as a periodic interrupt source. Software writes a start value, picks a prescale ratio and starts the counter. On every prescaler tick the count drops by one. A tick that finds the count already at zero is an expiry: the count is reloaded and an interrupt is raised. The reload value comes from one of two sources, selected by a control bit: the software load register, or a fixed ceiling of 0x7FFFFF.

Two interrupt styles are offered. In pulse (edge) mode the status flag is set for a single clock and then drops by itself, so every expiry gives a fresh one-cycle pulse on the interrupt line. In held (level) mode the flag stays set until software writes zero to the clear register. While the flag is held the count keeps running, and further expiries raise nothing new.

Two state machines form the core. The counter machine has the states HALT and COUNT. A control write with the run bit set moves it from HALT to COUNT. A control write with the run bit clear moves it from COUNT to HALT. The interrupt machine has the states IDLE, PULSE and HELD. An expiry in pulse mode moves it to PULSE. An expiry in held mode moves it to HELD. PULSE returns to IDLE on the next clock unless another expiry arrives. HELD returns to IDLE only on a clear write of zero.

The register interface is a plain single-cycle bus. Reads are combinational from the address. Writes take effect at the clock edge where the write enable is high.

Top module: `tmr_down_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq_o` is low.
- R2: Register offsets are: 0x0 load (read/write), 0x4 count (read-only), 0x8 control, 0xC clear. A load write while the timer is in HALT also sets the count to the written value.
- R3: In COUNT, each prescaler tick on a nonzero count lowers the count by one. Expiries are therefore load+1 ticks apart. In HALT the count does not change.
- R4: With control bit 6 set, an expiry reloads the count from the load register. The reloaded value is readable in the cycle in which the interrupt is high.
- R5: With control bit 6 clear, an expiry reloads the count with 0x7FFFFF.
- R6: Control bits 3:2 set the prescale ratio. 00 gives one tick per clock. 01 gives one tick every 16 clocks. 10 or 11 gives one tick every 256 clocks. The prescaler runs freely.
- R7: With control bit 0 clear (pulse mode), each expiry drives `irq_o` high for exactly one clock. Status bit 8 of the control register reads 1 in that clock and 0 in the next, with no software action.
- R8: With control bit 0 set (held mode), `irq_o` and status bit 8 stay high after an expiry while the count keeps running. After a clear, the next expiry raises them again.
- R9: A write of zero to the clear register ends the held state, so `irq_o` is low from the next clock. A write of a nonzero value to the clear register has no effect.
- R10: A read of the clear register returns the load register value.
- R11: A load write while the timer is in COUNT changes only the load register, not the running count.
- R12: Control bit 7 is run and reads back the counter state. Status bit 8 is read-only: writing a 1 to it neither sets the status nor raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W (4) | Byte address of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_we_i | input | 1 | Write enable, one write per high cycle |
| bus_rdata_o | output | DATA_W (32) | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that only one register is written per cycle. They also assume that a clear write and an expiry never fall in the same cycle while the flag is held. The stimulus meets both. It issues each write on its own falling-edge-aligned cycle and does not write the clear register until after the flag has been seen high. To avoid races between a load write and a running reload, every restart stops the timer with a control write before it writes the load register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CB_LEVEL  = 0;
    localparam int CB_DIV_LO = 2;
    localparam int CB_DIV_HI = 3;
    localparam int CB_RELOAD = 6;
    localparam int CB_RUN    = 7;
    localparam int CB_STATUS = 8;

    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_t;

    typedef enum logic {
        CS_HALT  = 1'b0,
        CS_COUNT = 1'b1
    } cnt_state_t;

    typedef enum logic [1:0] {
        IS_IDLE  = 2'd0,
        IS_PULSE = 2'd1,
        IS_HELD  = 2'd2
    } irq_state_t;

    typedef struct packed {
        logic       level;
        logic [1:0] div;
        logic       reload;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int MID_LOG  = 4,
    parameter int HIGH_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    output logic       tick
);
    localparam int PRE_W = HIGH_LOG;

    logic [PRE_W-1:0] pre_q;
    logic             wrap_mid;
    logic             wrap_high;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
        end
    end

    assign wrap_mid  = &pre_q[MID_LOG-1:0];
    assign wrap_high = &pre_q;

    always_comb begin
        if (div_sel[1]) begin
            tick = wrap_high;
        end else if (div_sel[0]) begin
            tick = wrap_mid;
        end else begin
            tick = 1'b1;
        end
    end

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              run,
    input  logic              status,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  load_q,
    output ctrl_t             ctrl_q,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic              run_wr,
    output logic              clr_zero,
    output logic [CNT_W-1:0]  wr_val,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] OFF_LOAD  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_COUNT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFF_CLEAR = ADDR_W'(12);
    localparam int PAD_W = DATA_W - CNT_W;

    reg_sel_t          sel;
    logic              hit;
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        hit = 1'b1;
        sel = SEL_LOAD;
        unique case (addr)
            OFF_LOAD:  sel = SEL_LOAD;
            OFF_COUNT: sel = SEL_COUNT;
            OFF_CTRL:  sel = SEL_CTRL;
            OFF_CLEAR: sel = SEL_CLEAR;
            default:   hit = 1'b0;
        endcase
    end

    assign load_wr  = we && hit && (sel == SEL_LOAD);
    assign ctrl_wr  = we && hit && (sel == SEL_CTRL);
    assign clr_zero = we && hit && (sel == SEL_CLEAR) && (wdata == '0);
    assign run_wr   = wdata[CB_RUN];
    assign wr_val   = wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (load_wr) begin
                load_q <= wdata[CNT_W-1:0];
            end
            if (ctrl_wr) begin
                ctrl_q.level  <= wdata[CB_LEVEL];
                ctrl_q.div    <= wdata[CB_DIV_HI:CB_DIV_LO];
                ctrl_q.reload <= wdata[CB_RELOAD];
            end
        end
    end

    always_comb begin
        ctrl_word                      = '0;
        ctrl_word[CB_LEVEL]            = ctrl_q.level;
        ctrl_word[CB_DIV_HI:CB_DIV_LO] = ctrl_q.div;
        ctrl_word[CB_RELOAD]           = ctrl_q.reload;
        ctrl_word[CB_RUN]              = run;
        ctrl_word[CB_STATUS]           = status;
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_LOAD:  rdata = {{PAD_W{1'b0}}, load_q};
                SEL_COUNT: rdata = {{PAD_W{1'b0}}, cnt};
                SEL_CTRL:  rdata = ctrl_word;
                SEL_CLEAR: rdata = {{PAD_W{1'b0}}, load_q};
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int               CNT_W    = 24,
    parameter logic [CNT_W-1:0] MAX_LOAD = 24'h7F_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             run_wr,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             reload_sel,
    input  logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_t       state_q;
    cnt_state_t       state_d;
    logic [CNT_W-1:0] reload_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HALT:  if (ctrl_wr && run_wr)  state_d = CS_COUNT;
            CS_COUNT: if (ctrl_wr && !run_wr) state_d = CS_HALT;
            default:  state_d = CS_HALT;
        endcase
    end

    always_comb begin
        run        = (state_q == CS_COUNT);
        expire     = run && tick && (cnt_q == '0);
        reload_val = reload_sel ? load_q : MAX_LOAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                CS_HALT: begin
                    if (load_wr) begin
                        cnt_q <= wr_val;
                    end
                end
                CS_COUNT: begin
                    if (tick) begin
                        cnt_q <= (cnt_q == '0) ? reload_val : (cnt_q - ONE);
                    end
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic level,
    input  logic clr_zero,
    output logic irq,
    output logic status,
    output logic held
);
    irq_state_t state_q;
    irq_state_t state_d;
    irq_state_t fire_to;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fire_to = level ? IS_HELD : IS_PULSE;
        state_d = state_q;
        unique case (state_q)
            IS_IDLE:  if (expire) state_d = fire_to;
            IS_PULSE: state_d = expire ? fire_to : IS_IDLE;
            IS_HELD:  if (clr_zero) state_d = IS_IDLE;
            default:  state_d = IS_IDLE;
        endcase
    end

    always_comb begin
        irq    = 1'b0;
        status = 1'b0;
        held   = 1'b0;
        unique case (state_q)
            IS_IDLE:  ;
            IS_PULSE: begin
                irq    = 1'b1;
                status = 1'b1;
            end
            IS_HELD: begin
                irq    = 1'b1;
                status = 1'b1;
                held   = 1'b1;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/tmr_down_timer.sv
module tmr_down_timer
    import tmr_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter int               DATA_W   = 32,
    parameter int               CNT_W    = 24,
    parameter logic [CNT_W-1:0] MAX_LOAD = 24'h7F_FFFF,
    parameter int               MID_LOG  = 4,
    parameter int               HIGH_LOG = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wr_val;
    logic             load_wr;
    logic             ctrl_wr;
    logic             run_wr;
    logic             clr_zero;
    logic             tick;
    logic             run_q;
    logic             expire;
    logic             status;
    logic             held;

    tmr_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .addr     (bus_addr_i),
        .wdata    (bus_wdata_i),
        .we       (bus_we_i),
        .run      (run_q),
        .status   (status),
        .cnt      (cnt_q),
        .load_q   (load_q),
        .ctrl_q   (ctrl_q),
        .load_wr  (load_wr),
        .ctrl_wr  (ctrl_wr),
        .run_wr   (run_wr),
        .clr_zero (clr_zero),
        .wr_val   (wr_val),
        .rdata    (bus_rdata_o)
    );

    tmr_prescaler #(
        .MID_LOG  (MID_LOG),
        .HIGH_LOG (HIGH_LOG)
    ) u_pre (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .div_sel (ctrl_q.div),
        .tick    (tick)
    );

    tmr_counter #(
        .CNT_W    (CNT_W),
        .MAX_LOAD (MAX_LOAD)
    ) u_cnt (
        .clk        (clk_i),
        .rst_n      (rst_ni),
        .tick       (tick),
        .ctrl_wr    (ctrl_wr),
        .run_wr     (run_wr),
        .load_wr    (load_wr),
        .wr_val     (wr_val),
        .reload_sel (ctrl_q.reload),
        .load_q     (load_q),
        .cnt_q      (cnt_q),
        .run        (run_q),
        .expire     (expire)
    );

    tmr_irq u_irq (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .expire   (expire),
        .level    (ctrl_q.level),
        .clr_zero (clr_zero),
        .irq      (irq_o),
        .status   (status),
        .held     (held)
    );

endmodule

// File: rtl/tmr_down_timer_chk.sv
module tmr_down_timer_chk #(
    parameter int               ADDR_W   = 4,
    parameter int               DATA_W   = 32,
    parameter int               CNT_W    = 24,
    parameter logic [CNT_W-1:0] MAX_LOAD = 24'h7F_FFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              tick,
    input logic              run,
    input logic              reload,
    input logic              held,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);
    localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(12);

    logic load_w;
    logic clr0_w;
    assign load_w = we && (addr == A_LOAD);
    assign clr0_w = we && (addr == A_CLEAR) && (wdata == '0);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick && (cnt != '0) |=> cnt == $past(cnt) - ONE);  // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(cnt));  // R3
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load_w |=> $stable(cnt));  // R3
    AST_MAX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick && (cnt == '0) && !reload |=> cnt == MAX_LOAD);  // R5
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(run && tick && (cnt == '0)));  // R7
    AST_HELD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        held && !clr0_w |=> held && irq);  // R8
    AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        held && clr0_w |=> !irq);  // R9

endmodule

bind tmr_down_timer tmr_down_timer_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .MAX_LOAD (MAX_LOAD)
) u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .we     (bus_we_i),
    .addr   (bus_addr_i),
    .wdata  (bus_wdata_i),
    .irq    (irq_o),
    .tick   (tick),
    .run    (run_q),
    .reload (ctrl_q.reload),
    .held   (held),
    .cnt    (cnt_q)
);

// File: tb/test_tmr_down_timer.sv
`timescale 1ns/1ps
module test_tmr_down_timer;

    localparam logic [3:0] A_LOAD = 4'h0;
    localparam logic [3:0] A_CNT  = 4'h4;
    localparam logic [3:0] A_CTRL = 4'h8;
    localparam logic [3:0] A_CLR  = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tmr_down_timer i_tmr_down_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_now(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_rise(input int limit, output int n);
        logic prev;
        prev = irq;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (irq && !prev) break;
            prev = irq;
            if (n >= limit) begin
                n = -1;
                break;
            end
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            rd_now(4'(i * 4), d);
            chk(d == 0, "R1 register after reset", d, 0);
        end
        chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    endtask

    task automatic t_status_ro;
        logic [31:0] d;
        wr(A_CTRL, 32'h100);
        rd_now(A_CTRL, d);
        chk(d == 0, "R12 status bit not writable", d, 0);
        chk(irq == 1'b0, "R12 irq stays low", 32'(irq), 0);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        int n;
        wr(A_LOAD, 32'd5);
        rd_now(A_CNT, d);
        chk(d == 5, "R2 load while halted sets count", d, 5);
        wr(A_CTRL, 32'hC0);
        rd_now(A_CTRL, d);
        chk(d == 32'hC0, "R12 run readback", d, 32'hC0);
        wait_rise(50, n);
        chk(n > 0, "R7 first pulse", 32'(n), 1);
        rd_now(A_CNT, d);
        chk(d == 5, "R4 reload from load register", d, 5);
        rd_now(A_CTRL, d);
        chk(d[8] == 1'b1, "R7 status during pulse", d, 32'h1C0);
        @(negedge clk);
        chk(irq == 1'b0, "R7 pulse one clock wide", 32'(irq), 0);
        rd_now(A_CTRL, d);
        chk(d[8] == 1'b0, "R7 status self clears", d, 32'hC0);
        rd_now(A_CNT, d);
        chk(d == 4, "R3 decrement per tick", d, 4);
        wait_rise(50, n);
        chk(n == 5, "R3 expiry spacing load+1", 32'(n), 5);
        wait_rise(50, n);
        chk(n == 6, "R7 re-raise without software", 32'(n), 6);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_max_reload;
        logic [31:0] d;
        int n;
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'h80);
        wait_rise(50, n);
        rd_now(A_CNT, d);
        chk(d == 32'h7FFFFF, "R5 fixed ceiling reload", d, 32'h7FFFFF);
        @(negedge clk);
        rd_now(A_CNT, d);
        chk(d == 32'h7FFFFE, "R3 decrement after ceiling", d, 32'h7FFFFE);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_halt_frozen;
        logic [31:0] a, b;
        bit quiet;
        rd_now(A_CNT, a);
        quiet = 1;
        repeat (8) begin
            @(negedge clk);
            if (irq) quiet = 0;
        end
        rd_now(A_CNT, b);
        chk(a == b, "R3 count frozen in HALT", b, a);
        chk(quiet, "R3 no irq in HALT", 32'(quiet), 1);
    endtask

    task automatic t_level;
        logic [31:0] d, e;
        int n;
        bit stuck;
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'hC1);
        wait_rise(50, n);
        chk(n > 0, "R8 held raise", 32'(n), 1);
        stuck = 1;
        repeat (10) begin
            @(negedge clk);
            if (!irq) stuck = 0;
        end
        chk(stuck, "R8 irq stays high", 32'(stuck), 1);
        rd_now(A_CNT, d);
        @(negedge clk);
        rd_now(A_CNT, e);
        chk(d != e, "R8 count runs while held", e, d);
        wr(A_CLR, 32'h1);
        rd_now(A_CTRL, d);
        chk(irq && d[8], "R9 nonzero clear ignored", d, 32'h1C1);
        rd_now(A_CLR, d);
        chk(d == 3, "R10 clear reads load value", d, 3);
        wr(A_CLR, 32'h0);
        chk(irq == 1'b0, "R9 zero clear drops irq", 32'(irq), 0);
        wait_rise(20, n);
        chk(n > 0, "R8 re-raise after clear", 32'(n), 1);
        wr(A_CLR, 32'h0);
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h0);
    endtask

    task automatic t_load_running;
        logic [31:0] d;
        wr(A_LOAD, 32'd1000);
        wr(A_CTRL, 32'hC0);
        repeat (5) @(negedge clk);
        wr(A_LOAD, 32'd7);
        rd_now(A_CNT, d);
        chk(d > 7 && d <= 1000, "R11 running count untouched", d, 990);
        rd_now(A_LOAD, d);
        chk(d == 7, "R11 load register updated", d, 7);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_prescale(input logic [31:0] ctrl, input logic [31:0] ld, input int expect_n, input string tag);
        int n;
        wr(A_LOAD, ld);
        wr(A_CTRL, ctrl);
        wait_rise(1200, n);
        wait_rise(1200, n);
        chk(n == expect_n, tag, 32'(n), 32'(expect_n));
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_ro();
        t_edge();
        t_max_reload();
        t_halt_frozen();
        t_level();
        t_load_running();
        t_prescale(32'hC4, 32'd1, 32,  "R6 divide by 16");
        t_prescale(32'hC8, 32'd0, 256, "R6 divide by 256");
        t_prescale(32'hCC, 32'd0, 256, "R6 both bits divide by 256");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule